// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block counts cycles of a VCO-rate clock and emits one comparison pulse per programmed period, so that a phase detector sees the VCO divided by a ratio of P·N + A + F/Q. The prescaler ratio P is fixed at 32. Each period is built from N groups of input cycles. The first A groups are one cycle longer (P+1) and the rest are P cycles. The block models the prescaler as a cycle counter and does not reproduce any analog behaviour.

A fractional accumulator steps by the numerator F at every period boundary. When the sum reaches the denominator Q, the accumulator subtracts Q and the following period gets one extra input cycle. Averaged over Q periods, the ratio therefore carries the fraction F/Q. The select input `qm_set` chooses Q = 8 when it is 1 and Q = 5 when it is 0.

New settings are sampled only at a period boundary, or on every cycle while the block is disabled. A setting that breaks the legality rules is rejected: the last legal configuration stays in force and a sticky error flag is raised.

Top module: `fnd_frac_divider`

## Requirements
- R1: After reset `fp`, `carry` and `cfg_err` are 0, and the active configuration is N=34, A=0, F=0, Q=5.
- R2: With F=0, enabled pulses on `fp` are exactly 32·N + A enabled cycles apart, and each pulse lasts one cycle. The first pulse after enable comes on the (32·N+A)-th enabled rising edge.
- R3: With `qm_set`=1 (Q=8), any 8 consecutive periods total 8·(32·N+A)+F cycles. `carry` is 1 exactly during periods that carry the extra cycle, and the accumulator always stays below Q.
- R4: With `qm_set`=0 (Q=5), any 5 consecutive periods total 5·(32·N+A)+F cycles, following the same carry rule.
- R5: A change of `n_set`, `a_set`, `f_set` or `qm_set` during a period does not alter that period. It takes effect at the edge on which `fp` rises.
- R6: A candidate setting is illegal if N<34, A+2≥N, or F≥Q. An illegal candidate sets `cfg_err`, which stays 1 until reset, and the previous configuration keeps running. Because A is 5 bits wide, the A rule can only fail together with the N rule.
- R7: While `en` is 0, `fp` and `carry` stay 0, the group counter and the accumulator are cleared, and the inputs are loaded on every cycle. After `en` returns to 1, the first period has full length.
- R8: When a load changes the Q select, the accumulator restarts from 0 before F is added. For example, an accumulator at 7 with Q=8, switched to Q=5 with F=4, gives no carry in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Divider run enable |
| n_set | input | 10 | Main group count N |
| a_set | input | 5 | Swallow group count A |
| f_set | input | 4 | Fractional numerator F |
| qm_set | input | 1 | Denominator select: 1 gives Q=8, 0 gives Q=5 |
| fp | output | 1 | One-cycle comparison pulse at the end of each period |
| carry | output | 1 | High during a period extended by one cycle |
| cfg_err | output | 1 | Sticky flag for a rejected setting |

## Verification
A wrong group or prescaler count appears as an `fp` spacing that differs from 32·N+A by a few cycles. The first pulse after enable exposes it, roughly a thousand cycles in. A wrong accumulator value does not show at once. It shifts which period has `carry` high and one extra cycle, so it is caught by the lockstep comparison at the first affected boundary, and by the summed length over Q periods. A wrong load rule shows up as a period of the wrong length immediately after the boundary, or as `cfg_err` taking the wrong value.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
    localparam int NW = 10;  // main group count width
    localparam int AW = 5;   // swallow count width
    localparam int FW = 4;   // fractional numerator width

    typedef struct packed {
        logic [NW-1:0] n;
        logic [AW-1:0] a;
        logic [FW-1:0] f;
        logic          qm;
    } cfg_t;
endpackage

// File: rtl/fnd_cfg_check.sv
// Legality of a candidate setting (R6)
module fnd_cfg_check #(
    parameter int N_MIN = 34,
    parameter int Q_LO  = 5,
    parameter int Q_HI  = 8
) (
    input  fnd_pkg::cfg_t cand,
    output logic          legal
);
    import fnd_pkg::*;

    logic [NW:0] a_lim;
    logic [NW:0] n_ext;
    logic [FW:0] q_val;

    always_comb begin
        n_ext = {1'b0, cand.n};
        a_lim = {{(NW-AW+1){1'b0}}, cand.a} + (NW+1)'(2);
        q_val = cand.qm ? (FW+1)'(Q_HI) : (FW+1)'(Q_LO);
        legal = (n_ext >= (NW+1)'(N_MIN)) && (a_lim < n_ext) && ({1'b0, cand.f} < q_val);
    end
endmodule

// File: rtl/fnd_frac_acc.sv
// Fractional accumulator: steps by F at each boundary, flags the extended period
module fnd_frac_acc #(
    parameter int FW   = 4,
    parameter int Q_LO = 5,
    parameter int Q_HI = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          restart,
    input  logic [FW-1:0] f_num,
    input  logic          qm,
    output logic [FW-1:0] acc,
    output logic          carry
);
    typedef struct packed {
        logic [FW-1:0] acc;
        logic          carry;
    } acc_st_t;

    acc_st_t     st_d, st_q;
    logic [FW:0] base, sum, q_val;

    always_comb begin
        q_val = qm ? (FW+1)'(Q_HI) : (FW+1)'(Q_LO);
        base  = restart ? '0 : {1'b0, st_q.acc};        // R8
        sum   = base + {1'b0, f_num};
        st_d  = st_q;
        if (clr) begin
            st_d = '0;                                  // R7
        end else if (step) begin
            if (sum >= q_val) begin                     // R3 R4
                st_d.acc   = FW'(sum - q_val);
                st_d.carry = 1'b1;
            end else begin
                st_d.acc   = sum[FW-1:0];
                st_d.carry = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc   = st_q.acc;
    assign carry = st_q.carry;
endmodule

// File: rtl/fnd_group_ctr.sv
// Prescaler and group counter: A groups of P+1, then groups of P, last group +ext
module fnd_group_ctr #(
    parameter int PRESC = 32,
    parameter int NW    = 10,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [NW-1:0] n_div,
    input  logic [AW-1:0] a_swl,
    input  logic          ext,
    output logic          period_end
);
    localparam int PW = $clog2(PRESC + 2);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [NW-1:0] grp;
    } ctr_st_t;

    ctr_st_t       st_d, st_q;
    logic          swallow, last_grp, grp_done;
    logic [PW-1:0] mod_m1;

    always_comb begin
        swallow    = {{(NW-AW){1'b0}}, a_swl} > st_q.grp;
        last_grp   = st_q.grp == (n_div - NW'(1));
        mod_m1     = PW'(PRESC - 1) + PW'(swallow) + PW'(last_grp & ext);
        grp_done   = st_q.pre == mod_m1;
        period_end = run && grp_done && last_grp;          // R2
        st_d       = st_q;
        if (!run) begin
            st_d = '0;                                      // R7
        end else if (grp_done) begin
            st_d.pre = '0;
            st_d.grp = last_grp ? '0 : st_q.grp + NW'(1);
        end else begin
            st_d.pre = st_q.pre + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fnd_frac_divider.sv
module fnd_frac_divider #(
    parameter int PRESC = 32,
    parameter int N_MIN = 34,
    parameter int Q_LO  = 5,
    parameter int Q_HI  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [fnd_pkg::NW-1:0] n_set,
    input  logic [fnd_pkg::AW-1:0] a_set,
    input  logic [fnd_pkg::FW-1:0] f_set,
    input  logic                   qm_set,
    output logic                   fp,
    output logic                   carry,
    output logic                   cfg_err
);
    import fnd_pkg::*;

    typedef struct packed {
        cfg_t cfg;
        logic fp;
        logic err;
    } top_st_t;

    localparam cfg_t CFG_RST = '{n: NW'(N_MIN), a: '0, f: '0, qm: 1'b0};  // R1

    top_st_t       st_d, st_q;
    cfg_t          cand;
    logic          legal, load, period_end, restart, carry_w;
    logic [NW-1:0] act_n;
    logic [FW-1:0] acc_w;

    assign cand  = '{n: n_set, a: a_set, f: f_set, qm: qm_set};
    assign act_n = st_q.cfg.n;

    fnd_cfg_check #(.N_MIN(N_MIN), .Q_LO(Q_LO), .Q_HI(Q_HI)) u_check (
        .cand  (cand),
        .legal (legal)
    );

    always_comb begin
        load    = !en || period_end;                         // R5 R7
        st_d    = st_q;
        st_d.fp = period_end;
        if (load) begin
            if (legal) st_d.cfg = cand;
            else       st_d.err = 1'b1;                      // R6
        end
    end

    assign restart = st_d.cfg.qm != st_q.cfg.qm;             // R8

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: CFG_RST, fp: 1'b0, err: 1'b0};
        else        st_q <= st_d;
    end

    fnd_group_ctr #(.PRESC(PRESC), .NW(NW), .AW(AW)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en),
        .n_div      (act_n),
        .a_swl      (st_q.cfg.a),
        .ext        (carry_w),
        .period_end (period_end)
    );

    fnd_frac_acc #(.FW(FW), .Q_LO(Q_LO), .Q_HI(Q_HI)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!en),
        .step    (period_end),
        .restart (restart),
        .f_num   (st_d.cfg.f),
        .qm      (st_d.cfg.qm),
        .acc     (acc_w),
        .carry   (carry_w)
    );

    assign fp      = st_q.fp;
    assign carry   = carry_w;
    assign cfg_err = st_q.err;
endmodule

// File: rtl/fnd_frac_divider_chk.sv
module fnd_frac_divider_chk #(
    parameter int N_MIN = 34,
    parameter int Q_LO  = 5,
    parameter int Q_HI  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   en,
    input logic                   fp,
    input logic                   carry,
    input logic                   cfg_err,
    input logic [fnd_pkg::NW-1:0] cfg_n,
    input logic                   cfg_qm,
    input logic [fnd_pkg::FW-1:0] acc
);
    AST_FP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);                                                       // R2
    AST_FP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !fp);                                                      // R7
    AST_CARRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !carry);                                                   // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);                                              // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (fp || ($stable(cfg_n) && $stable(cfg_qm))));               // R5
    AST_N_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_n >= fnd_pkg::NW'(N_MIN));                                     // R6
    AST_ACC_BELOW_Q: assert property (@(posedge clk) disable iff (!rst_n)
        acc < (cfg_qm ? fnd_pkg::FW'(Q_HI) : fnd_pkg::FW'(Q_LO)));         // R3
endmodule

bind fnd_frac_divider fnd_frac_divider_chk #(.N_MIN(N_MIN), .Q_LO(Q_LO), .Q_HI(Q_HI)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .fp      (fp),
    .carry   (carry),
    .cfg_err (cfg_err),
    .cfg_n   (act_n),
    .cfg_qm  (st_q.cfg.qm),
    .acc     (acc_w)
);

// File: tb/fnd_frac_divider_bench.sv
`timescale 1ns/1ps
module fnd_frac_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [9:0] n_set = 10'd40;
    logic [4:0] a_set = 5'd5;
    logic [3:0] f_set = 4'd0;
    logic       qm_set = 1'b0;
    logic       fp, carry, cfg_err;

    always #2 clk = ~clk;

    fnd_frac_divider u_fnd_frac_divider (
        .clk(clk), .rst_n(rst_n), .en(en), .n_set(n_set), .a_set(a_set),
        .f_set(f_set), .qm_set(qm_set), .fp(fp), .carry(carry), .cfg_err(cfg_err)
    );

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // behavioural reference model
    int m_n = 34, m_a = 0, m_f = 0, m_qm = 0, m_cnt = 0, m_acc = 0;
    int old_qm, s, qv;
    bit m_fp = 0, m_carry = 0, m_err = 0;

    task automatic try_load();
        int qn;
        qn = qm_set ? 8 : 5;
        if (n_set >= 34 && a_set + 2 < n_set && f_set < qn) begin
            m_n = n_set; m_a = a_set; m_f = f_set; m_qm = qm_set;
        end else begin
            m_err = 1;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 34; m_a = 0; m_f = 0; m_qm = 0; m_cnt = 0; m_acc = 0;
            m_fp = 0; m_carry = 0; m_err = 0;
        end else if (!en) begin
            m_cnt = 0; m_acc = 0; m_carry = 0; m_fp = 0;
            try_load();
        end else begin
            m_cnt++;
            if (m_cnt == 32 * m_n + m_a + int'(m_carry)) begin
                m_cnt = 0; m_fp = 1; old_qm = m_qm;
                try_load();
                s  = ((m_qm != old_qm) ? 0 : m_acc) + m_f;
                qv = m_qm ? 8 : 5;
                if (s >= qv) begin m_acc = s - qv; m_carry = 1; end
                else begin m_acc = s; m_carry = 0; end
            end else begin
                m_fp = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (fp !== m_fp || carry !== m_carry || cfg_err !== m_err) begin
                errors++;
                $display("FAIL %s lockstep: actual fp=%0b carry=%0b err=%0b expected fp=%0b carry=%0b err=%0b",
                         tag, fp, carry, cfg_err, m_fp, m_carry, m_err);
            end
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(int n, int a, int f, int q);
        n_set = 10'(n); a_set = 5'(a); f_set = 4'(f); qm_set = 1'(q);
    endtask

    task automatic wait_fp(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!fp);
    endtask

    initial begin
        int c, total, idle_fp;
        repeat (3) @(negedge clk);
        chk("R1", fp, 0, "fp in reset");
        chk("R1", carry, 0, "carry in reset");
        chk("R1", cfg_err, 0, "cfg_err in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        tag = "R2"; en = 1'b1;
        wait_fp(c); chk("R2", c, 1285, "first period N=40 A=5");
        for (int k = 0; k < 2; k++) begin
            wait_fp(c); chk("R2", c, 1285, "period N=40 A=5");
        end
        tag = "R5";
        repeat (300) @(negedge clk);
        set_cfg(34, 31, 0, 0);
        wait_fp(c); chk("R5", c, 1285 - 300, "mid-period change ignored");
        tag = "R2";
        wait_fp(c); chk("R2", c, 1119, "period N=34 A=31");

        tag = "R3";
        set_cfg(34, 0, 3, 1);
        wait_fp(c);
        total = 0;
        for (int k = 0; k < 8; k++) begin wait_fp(c); total += c; end
        chk("R3", total, 8 * 1088 + 3, "8 periods Q=8 F=3");

        tag = "R4";
        set_cfg(34, 0, 4, 0);
        wait_fp(c);
        total = 0;
        for (int k = 0; k < 5; k++) begin wait_fp(c); total += c; end
        chk("R4", total, 5 * 1088 + 4, "5 periods Q=5 F=4");

        tag = "R7";
        @(negedge clk); en = 1'b0;
        set_cfg(34, 0, 7, 1);
        idle_fp = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (fp) idle_fp++; end
        chk("R7", idle_fp, 0, "fp pulses while disabled");
        chk("R7", carry, 0, "carry while disabled");
        en = 1'b1;
        wait_fp(c); chk("R7", c, 1088, "first period after enable");

        tag = "R8";
        set_cfg(34, 0, 4, 0);
        wait_fp(c); chk("R8", c, 1088, "period before Q switch");
        chk("R8", carry, 0, "carry after Q switch");
        wait_fp(c); chk("R8", c, 1088, "period after Q switch");

        tag = "R6";
        set_cfg(34, 0, 0, 0);
        wait_fp(c);
        set_cfg(20, 0, 0, 0);
        wait_fp(c); chk("R6", c, 1088, "period before illegal load");
        chk("R6", cfg_err, 1, "cfg_err after N=20");
        wait_fp(c); chk("R6", c, 1088, "old config kept");
        set_cfg(34, 0, 6, 0);
        wait_fp(c); chk("R6", cfg_err, 1, "cfg_err with F>=Q");
        set_cfg(35, 0, 0, 0);
        wait_fp(c);
        wait_fp(c); chk("R6", c, 1120, "legal load after error");
        chk("R6", cfg_err, 1, "cfg_err stays set");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL %s watchdog: actual=timeout expected=completion", tag);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule